// File: doc/BRIEF.md
# Carry-Chain Prefix Sequencer

This decode-stage block lets a short run of ordinary 64-bit adds chain their carries through a general register instead of through a flags register. A prefix instruction names one register to act as the carry container, supplies that register's current value, and gives a 16-bit immediate. The immediate holds one 2-bit tag for each of the eight instructions that follow. Each tag says whether that instruction takes its carry-in from the container, writes its carry-out back into it, both, or neither.

Decoded instructions arrive with a valid/ready handshake. The block applies the tag at the head of its shift register to the current instruction and drives the 64-bit adder. It shifts the next tag into place only when an instruction is accepted. When the tag asks for write-back, it raises a write strobe with the container's register index, so the register file can take the new container value. A wide add (for example 256 bits) is then a prefix followed by one add per 64-bit word. The final carry is left in the container as the top bit of the result.

Top module: `carry_chain_seq`

## Requirements
- R1: After reset the tag register is empty: tagIn and tagOut read 0, carryVal reads 0 and carryWe is low.
- R2: An accepted prefix (inValid, inReady and isPrefix high) loads prefixImm into the tag register. Bits [1:0] apply to the first instruction accepted after it. Each accepted non-prefix instruction shifts the register right by 2 bits.
- R3: In each 2-bit tag, bit 1 is the carry-in flag (shown on tagIn). When it is set, the adder's carry-in is carryVal bit 0. Otherwise the carry-in is 0, and sum = opA + opB + carry-in modulo 2^64.
- R4: In each tag, bit 0 is the carry-out flag (shown on tagOut). When an instruction with this flag set is accepted, carryWe is high in that cycle with carryIdx naming the container. From the next cycle, carryVal equals the adder's carry-out, zero-extended to 64 bits.
- R5: An instruction with tag 00 is an unmodified add with carry-in 0. It leaves carryVal unchanged and carryWe low.
- R6: Only eight instructions after a prefix are tagged. The ninth and later ones see tag 00.
- R7: A prefix accepted while earlier tags remain replaces those tags. It also loads carryVal from prefixInit and carryIdx from prefixIdx.
- R8: While inValid or inReady is low, the tag register and carryVal hold, and carryWe stays low.
- R9: flush empties the tag register at the next edge. An instruction accepted in the same cycle as flush has no effect on tags or carryVal and does not raise carryWe.
- R10: A prefix instruction never raises carryWe.
- R11: A prefix with tags 01, 11, 11, 11 followed by four word adds (low word first) gives the 256-bit sum in the four sums, and leaves bit 256 in carryVal bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Pipeline redirect; clears pending tags |
| inValid | input | 1 | Decoded instruction present |
| inReady | input | 1 | Downstream can accept the instruction |
| isPrefix | input | 1 | The instruction is a carry prefix |
| prefixImm | input | 16 | Eight 2-bit tags carried by the prefix |
| prefixIdx | input | 5 | Register index named as carry container |
| prefixInit | input | 64 | Current value of the named register |
| opA | input | 64 | First add operand |
| opB | input | 64 | Second add operand |
| sum | output | 64 | Adder result |
| carryOutBit | output | 1 | Adder carry-out |
| tagIn | output | 1 | Carry-in flag of the head tag |
| tagOut | output | 1 | Carry-out flag of the head tag |
| carryVal | output | 64 | Container contents |
| carryIdx | output | 5 | Container register index |
| carryWe | output | 1 | Container write-back strobe |

## Verification
Assertions check several rules on every cycle: tags hold during a stall, a flush empties them, an accepted instruction shifts them by one pair, a write-back stores exactly the zero-extended carry, a quiet tag leaves the container alone, and a prefix loads the container and index. The bench scenarios cover the rest. They show the arithmetic of a 256-bit chain against a wide reference sum, the end of tagging after eight instructions, a prefix replacing a live tag stream, and a flush discarding a same-cycle instruction.

// File: rtl/carry_seq_pkg.sv
package carry_seq_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadEn;   // prefix accepted: load container and index
    logic shiftEn;  // tagged instruction accepted
    logic wbEn;     // write carry-out into container
    logic cinEn;    // take carry-in from container
  } seq_strobe_t;
endpackage

// File: rtl/carry_seq_ctrl.sv
module carry_seq_ctrl
  import carry_seq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int TAG_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   instFire,
  input  logic                   isPrefix,
  input  logic [SLOTS*TAG_W-1:0] prefixImm,
  output seq_strobe_t            strobe,
  output logic                   tagIn,
  output logic                   tagOut
);
  localparam int IMM_W = SLOTS * TAG_W;

  logic [IMM_W-1:0] tagReg;
  logic [TAG_W-1:0] headTag;

  assign headTag = tagReg[TAG_W-1:0];
  assign tagOut  = headTag[0];
  assign tagIn   = headTag[1];

  always_comb begin
    strobe.loadEn  = instFire & isPrefix & ~flush;
    strobe.shiftEn = instFire & ~isPrefix & ~flush;
    strobe.wbEn    = strobe.shiftEn & tagOut;
    strobe.cinEn   = tagIn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             tagReg <= '0;
    else if (flush)         tagReg <= '0;
    else if (strobe.loadEn) tagReg <= prefixImm;
    else if (strobe.shiftEn) tagReg <= tagReg >> TAG_W;
  end

  assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!instFire && !flush) |=> $stable(tagReg));

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tagReg == '0));

  assert_shift_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.shiftEn |=> (tagReg == ($past(tagReg) >> TAG_W)));
endmodule

// File: rtl/carry_seq_dp.sv
module carry_seq_dp
  import carry_seq_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_strobe_t       strobe,
  input  logic [IDX_W-1:0]  prefixIdx,
  input  logic [DATA_W-1:0] prefixInit,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] sum,
  output logic              carryOutBit,
  output logic [DATA_W-1:0] carryVal,
  output logic [IDX_W-1:0]  carryIdx,
  output logic              carryWe
);
  localparam int WIDE_W = DATA_W + 1;

  logic             carryIn;
  logic [WIDE_W-1:0] wideSum;

  assign carryIn = strobe.cinEn & carryVal[0];
  assign wideSum = {1'b0, opA} + {1'b0, opB} + WIDE_W'(carryIn);
  assign sum         = wideSum[DATA_W-1:0];
  assign carryOutBit = wideSum[DATA_W];
  assign carryWe     = strobe.wbEn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carryVal <= '0;
      carryIdx <= '0;
    end else if (strobe.loadEn) begin
      carryVal <= prefixInit;
      carryIdx <= prefixIdx;
    end else if (strobe.wbEn) begin
      carryVal <= DATA_W'(carryOutBit);
    end
  end

  assert_wb_zero_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wbEn |=> (carryVal == DATA_W'($past(carryOutBit))));

  assert_quiet_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.shiftEn && !strobe.wbEn) |=> $stable(carryVal));

  assert_prefix_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadEn |=> (carryVal == $past(prefixInit) && carryIdx == $past(prefixIdx)));

  assert_prefix_no_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadEn |-> !carryWe);
endmodule

// File: rtl/carry_chain_seq.sv
module carry_chain_seq
  import carry_seq_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 5,
  parameter int SLOTS  = 8,
  parameter int TAG_W  = 2,
  localparam int IMM_W = SLOTS * TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              inValid,
  input  logic              inReady,
  input  logic              isPrefix,
  input  logic [IMM_W-1:0]  prefixImm,
  input  logic [IDX_W-1:0]  prefixIdx,
  input  logic [DATA_W-1:0] prefixInit,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] sum,
  output logic              carryOutBit,
  output logic              tagIn,
  output logic              tagOut,
  output logic [DATA_W-1:0] carryVal,
  output logic [IDX_W-1:0]  carryIdx,
  output logic              carryWe
);
  seq_strobe_t strobe;
  logic        instFire;

  assign instFire = inValid & inReady;

  carry_seq_ctrl #(.SLOTS(SLOTS), .TAG_W(TAG_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .instFire(instFire),
    .isPrefix(isPrefix), .prefixImm(prefixImm), .strobe(strobe),
    .tagIn(tagIn), .tagOut(tagOut)
  );

  carry_seq_dp #(.DATA_W(DATA_W), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .prefixIdx(prefixIdx),
    .prefixInit(prefixInit), .opA(opA), .opB(opB), .sum(sum),
    .carryOutBit(carryOutBit), .carryVal(carryVal), .carryIdx(carryIdx),
    .carryWe(carryWe)
  );

  assert_stall_no_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !instFire |-> !carryWe);
endmodule

// File: tb/carry_chain_seq_tb_top.sv
module carry_chain_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0, inValid = 1'b0, inReady = 1'b0, isPrefix = 1'b0;
  logic [15:0] prefixImm = '0;
  logic [4:0]  prefixIdx = '0;
  logic [63:0] prefixInit = '0, opA = '0, opB = '0;
  logic [63:0] sum, carryVal;
  logic        carryOutBit, tagIn, tagOut, carryWe;
  logic [4:0]  carryIdx;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  logic [15:0] mTags = '0;
  logic [63:0] mCarry = '0;
  logic [4:0]  mIdx = '0;
  logic [63:0] lastSum;

  localparam logic [63:0] TAB_A [4] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF,
                                         64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001};
  localparam logic [63:0] TAB_B [4] = '{64'h0000_0000_0000_0001, 64'hFEDC_BA98_7654_3210,
                                         64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000};

  always #5 clk = ~clk;

  carry_chain_seq dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .inValid(inValid), .inReady(inReady),
    .isPrefix(isPrefix), .prefixImm(prefixImm), .prefixIdx(prefixIdx),
    .prefixInit(prefixInit), .opA(opA), .opB(opB), .sum(sum),
    .carryOutBit(carryOutBit), .tagIn(tagIn), .tagOut(tagOut),
    .carryVal(carryVal), .carryIdx(carryIdx), .carryWe(carryWe)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req, input logic pre, input logic [4:0] idx,
                      input logic [15:0] imm, input logic [63:0] a, input logic [63:0] b,
                      input logic v, input logic rdy, input logic fl);
    logic hs, tin, tout, cin, we;
    logic [64:0] w;
    @(negedge clk);
    isPrefix = pre; prefixIdx = idx; prefixImm = imm; prefixInit = a;
    opA = a; opB = b; inValid = v; inReady = rdy; flush = fl;
    #1;
    hs = v & rdy; tin = mTags[1]; tout = mTags[0]; cin = tin & mCarry[0];
    w = {1'b0, a} + {1'b0, b} + 65'(cin);
    we = hs & ~fl & ~pre & tout;
    chk(req, "tags", 64'({tagIn, tagOut}), 64'({tin, tout}));
    chk(req, "carryVal", carryVal, mCarry);
    chk(req, "carryWe", 64'(carryWe), 64'(we));
    if (!pre) begin
      chk(req, "sum", sum, w[63:0]);
      chk(req, "carryOutBit", 64'(carryOutBit), 64'(w[64]));
    end
    if (we) chk(req, "carryIdx", 64'(carryIdx), 64'(mIdx));
    lastSum = sum;
    @(posedge clk);
    if (fl) mTags = '0;
    else if (hs) begin
      if (pre) begin mTags = imm; mCarry = a; mIdx = idx; end
      else begin
        mTags = mTags >> 2;
        if (tout) mCarry = 64'(w[64]);
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [256:0] expWide;
    logic [255:0] gotWide;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "tags", 64'({tagIn, tagOut}), 64'd0);
    chk("R1", "carryVal", carryVal, 64'd0);
    chk("R1", "carryWe", 64'(carryWe), 64'd0);
    rst_n = 1'b1;

    // R11: 256-bit chain, tags 01,11,11,11 = 16'h00FD
    step("R11", 1, 5'd8, 16'h00FD, 64'hDEAD, 0, 1, 1, 0);
    for (int i = 0; i < 4; i++) begin
      step("R11", 0, 0, 0, TAB_A[i], TAB_B[i], 1, 1, 0);
      gotWide[i*64 +: 64] = lastSum;
    end
    expWide = {1'b0, TAB_A[3], TAB_A[2], TAB_A[1], TAB_A[0]} +
              {1'b0, TAB_B[3], TAB_B[2], TAB_B[1], TAB_B[0]};
    chk("R11", "low sum", gotWide[127:0] == expWide[127:0] ? 64'd1 : 64'd0, 64'd1);
    chk("R11", "high sum", gotWide[255:128] == expWide[255:128] ? 64'd1 : 64'd0, 64'd1);
    @(negedge clk); #1;
    chk("R11", "bit 256", carryVal, 64'(expWide[256]));

    // R6 / R2: eight tagged adds, ninth is plain
    step("R2", 1, 5'd2, 16'hFFFF, 64'h1, 0, 1, 1, 0);
    for (int i = 0; i < 8; i++) step("R2", 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'(i), 1, 1, 0);
    step("R6", 0, 0, 0, 64'h10, 64'h20, 1, 1, 0);
    chk("R6", "ninth sum", lastSum, 64'h30);

    // R3: carry-in only (tag 10), then R5 plain
    step("R3", 1, 5'd4, 16'h0002, 64'h1, 0, 1, 1, 0);
    step("R3", 0, 0, 0, 64'd5, 64'd6, 1, 1, 0);
    chk("R3", "sum with cin", lastSum, 64'd12);
    step("R5", 0, 0, 0, 64'd5, 64'd6, 1, 1, 0);
    chk("R5", "sum no cin", lastSum, 64'd11);
    step("R5", 0, 0, 0, 0, 0, 0, 0, 0);

    // R8: stall holds tag; then R4 write-back
    step("R8", 1, 5'd9, 16'h0001, 64'h0, 0, 1, 1, 0);
    step("R8", 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1, 0, 0);
    step("R8", 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 1, 0);
    step("R4", 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1, 1, 0);
    step("R4", 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R4", "container", carryVal, 64'd1);

    // R7: replace active prefix; R10 prefix never writes
    step("R7", 1, 5'd3, 16'h000F, 64'h0, 0, 1, 1, 0);
    step("R7", 0, 0, 0, 64'd1, 64'd2, 1, 1, 0);
    step("R10", 1, 5'd12, 16'h0001, 64'h80, 0, 1, 1, 0);
    step("R7", 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0);

    // R9: flush with same-cycle instruction
    step("R9", 1, 5'd7, 16'h00FF, 64'h1, 0, 1, 1, 0);
    step("R9", 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1, 1, 1);
    step("R9", 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1, 1, 0);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R9", "container kept", carryVal, 64'h1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule